// File: doc/BRIEF.md
# Special Instruction Decoder and Cycle Sequencer

This block sits beside the fetch and execute path of a small 16-bit processor. It recognises the special-instruction form, in which the low five bits of the word are all zero and a five-bit selector sits in bits 9:5 above them. It maps that selector onto an operation code and runs a per-operation cycle count. While the count runs, the block holds off the next issue. Operand addressing is resolved upstream, so the block receives the operand's value and address with the word.

For a subroutine call it produces a stack push of the return address one slot below the current stack pointer. In the last busy cycle of the call it produces a program-counter load with the operand value. Interrupt-side operations produce a one-cycle strobe to the interrupt unit. Device-side operations produce a one-cycle strobe to the device unit. In both cases the operand value and address are latched for the receiving unit. The reserved selector and every unassigned selector raise a one-cycle illegal flag and otherwise act as a one-cycle no-op. A device-interrupt operation can be stretched beyond its minimum count by a stall input from the device side.

Top module: `spx_sequencer`

## Requirements
- R1: A word is accepted as a special instruction only when bits 4:0 are all zero. An issued word with any of those bits set produces no strobe and no busy cycle, and it sets `op_code` to 0.
- R2: After acceptance, `op_code` holds the operation code until the next acceptance. The codes are: 1 call (selector 0x01), 2 software interrupt (0x08), 3 handler-address read (0x09), 4 handler-address write (0x0a), 5 interrupt return (0x0b), 6 queue control (0x0c), 7 device count (0x10), 8 device query (0x11), 9 device interrupt (0x12), 10 illegal (any other selector), 0 none. The reset value is 0.
- R3: Each operation takes a fixed number of cycles N, and `busy` is high for the N-1 cycles that follow the acceptance edge. N is 3 for call and interrupt return; 4 for software interrupt, device query and device interrupt; 2 for queue control and device count; 1 for handler-address read and write and for illegal selectors.
- R4: An issue presented while `busy` is high is ignored. Holding `issue` high with a call word accepts a new call exactly every 3 cycles.
- R5: A call raises `push_req` for the one cycle after acceptance. `push_addr` equals `sp_in`-1 and `push_data` equals `ret_pc`, both sampled at acceptance. These values hold until the next call.
- R6: A call raises `pc_load` for one cycle, in the second cycle after acceptance, which is the last busy cycle. `pc_target` then equals `opnd_val` sampled at acceptance. `pc_load` never occurs without a push in the cycle before it.
- R7: Selector 0x00 and every unassigned selector raise `illegal` for the one cycle after acceptance. They raise no other strobe and no busy cycle.
- R8: Selectors 0x08–0x0c raise `int_go` for one cycle after acceptance. Selectors 0x10–0x12 raise `dev_go` for one cycle after acceptance. In both cases `arg_val` and `arg_addr` latch `opnd_val` and `opnd_addr`. At most one of `int_go`, `dev_go`, `illegal`, `push_req` is high in any cycle.
- R9: During a device interrupt, while `dev_stall` is high in its last busy cycle, `busy` stays high. The count then finishes one cycle after `dev_stall` is low.
- R10: While `rst` is high and after it, all outputs are zero until the first acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction word presented this cycle |
| instr | input | 16 | Fetched instruction word |
| opnd_val | input | 16 | Resolved value of the six-bit operand field |
| opnd_addr | input | 16 | Resolved address of the operand |
| ret_pc | input | 16 | Address of the following instruction |
| sp_in | input | 16 | Current stack pointer |
| dev_stall | input | 1 | Device side extends a device interrupt |
| busy | output | 1 | Sequencer occupied; next issue held off |
| op_code | output | 4 | Decoded operation code |
| illegal | output | 1 | One-cycle illegal-selector flag |
| int_go | output | 1 | One-cycle strobe to interrupt unit |
| dev_go | output | 1 | One-cycle strobe to device unit |
| arg_val | output | 16 | Latched operand value for dispatch |
| arg_addr | output | 16 | Latched operand address for dispatch |
| push_req | output | 1 | Stack write request |
| push_addr | output | 16 | Stack write address (new stack pointer) |
| push_data | output | 16 | Return address to write |
| pc_load | output | 1 | Program-counter load request |
| pc_target | output | 16 | New program-counter value |

## Verification
All 32 selectors are issued one after another with distinct operand, return-address and stack-pointer values. This separates the costs and strobes of neighbouring selectors and catches a wrong boundary between the assigned and unassigned ranges. A word with a nonzero low field follows a dispatched operation, which shows whether a basic instruction leaks through as special. Holding `issue` high across a run of calls tells a correct hold-off from one that accepts too early or too late. Holding `dev_stall` through a device interrupt, and comparing that with the same operation unstalled, tells the stretch apart from the fixed count.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_CALL  = 4'd1,
    OP_SWI   = 4'd2,
    OP_IAGET = 4'd3,
    OP_IASET = 4'd4,
    OP_RFI   = 4'd5,
    OP_IAQ   = 4'd6,
    OP_HWCNT = 4'd7,
    OP_HWQRY = 4'd8,
    OP_HWINT = 4'd9,
    OP_BAD   = 4'd10
  } xop_e;

  typedef enum logic [1:0] {
    U_CORE = 2'd0,
    U_INT  = 2'd1,
    U_DEV  = 2'd2
  } unit_e;

  localparam logic [4:0] SEL_CALL  = 5'h01;
  localparam logic [4:0] SEL_SWI   = 5'h08;
  localparam logic [4:0] SEL_IAGET = 5'h09;
  localparam logic [4:0] SEL_IASET = 5'h0a;
  localparam logic [4:0] SEL_RFI   = 5'h0b;
  localparam logic [4:0] SEL_IAQ   = 5'h0c;
  localparam logic [4:0] SEL_HWCNT = 5'h10;
  localparam logic [4:0] SEL_HWQRY = 5'h11;
  localparam logic [4:0] SEL_HWINT = 5'h12;
endpackage

// File: rtl/spx_decode.sv
module spx_decode
  import spx_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int LOW_W   = 5,
  parameter int SEL_W   = 5,
  parameter int C_CALL  = 3,
  parameter int C_SWI   = 4,
  parameter int C_IA    = 1,
  parameter int C_RFI   = 3,
  parameter int C_IAQ   = 2,
  parameter int C_HWCNT = 2,
  parameter int C_HWQRY = 4,
  parameter int C_HWINT = 4
) (
  input  logic [WORD_W-1:0] word,
  output logic              special,
  output xop_e              op,
  output unit_e             unit,
  output logic [CNT_W-1:0]  cost
);
  logic [SEL_W-1:0] sel;

  assign special = (word[LOW_W-1:0] == '0);
  assign sel     = word[LOW_W +: SEL_W];

  always_comb begin
    op   = OP_BAD;
    unit = U_CORE;
    cost = CNT_W'(1);
    unique case (sel)
      SEL_CALL:  begin op = OP_CALL;  cost = CNT_W'(C_CALL);  end
      SEL_SWI:   begin op = OP_SWI;   unit = U_INT; cost = CNT_W'(C_SWI);   end
      SEL_IAGET: begin op = OP_IAGET; unit = U_INT; cost = CNT_W'(C_IA);    end
      SEL_IASET: begin op = OP_IASET; unit = U_INT; cost = CNT_W'(C_IA);    end
      SEL_RFI:   begin op = OP_RFI;   unit = U_INT; cost = CNT_W'(C_RFI);   end
      SEL_IAQ:   begin op = OP_IAQ;   unit = U_INT; cost = CNT_W'(C_IAQ);   end
      SEL_HWCNT: begin op = OP_HWCNT; unit = U_DEV; cost = CNT_W'(C_HWCNT); end
      SEL_HWQRY: begin op = OP_HWQRY; unit = U_DEV; cost = CNT_W'(C_HWQRY); end
      SEL_HWINT: begin op = OP_HWINT; unit = U_DEV; cost = CNT_W'(C_HWINT); end
      default:   begin op = OP_BAD;   cost = CNT_W'(1); end
    endcase
  end
endmodule

// File: rtl/spx_timer.sv
module spx_timer
  import spx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = cnt;
    if (start)
      nxt = load;
    else if (cnt != '0 && !(cnt == CNT_W'(1) && hold))
      nxt = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      cnt  <= nxt;
      busy <= (nxt != '0);
    end
  end
endmodule

// File: rtl/spx_stack.sv
module spx_stack
  import spx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LOAD_AT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_start,
  input  logic              call_act,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] ret_pc,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] target,
  output logic              push_req,
  output logic [DATA_W-1:0] push_addr,
  output logic [DATA_W-1:0] push_data,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_target
);
  always_ff @(posedge clk) begin
    if (rst) begin
      push_req  <= 1'b0;
      push_addr <= '0;
      push_data <= '0;
      pc_load   <= 1'b0;
      pc_target <= '0;
    end else begin
      push_req <= call_start;
      pc_load  <= call_act && (cnt == CNT_W'(LOAD_AT));
      if (call_start) begin
        push_addr <= sp_in - DATA_W'(1);
        push_data <= ret_pc;
        pc_target <= target;
      end
    end
  end
endmodule

// File: rtl/spx_sequencer.sv
module spx_sequencer
  import spx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [WORD_W-1:0] instr,
  input  logic [DATA_W-1:0] opnd_val,
  input  logic [DATA_W-1:0] opnd_addr,
  input  logic [DATA_W-1:0] ret_pc,
  input  logic [DATA_W-1:0] sp_in,
  input  logic              dev_stall,
  output logic              busy,
  output logic [3:0]        op_code,
  output logic              illegal,
  output logic              int_go,
  output logic              dev_go,
  output logic [DATA_W-1:0] arg_val,
  output logic [DATA_W-1:0] arg_addr,
  output logic              push_req,
  output logic [DATA_W-1:0] push_addr,
  output logic [DATA_W-1:0] push_data,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_target
);
  logic             special;
  xop_e             dec_op;
  unit_e            dec_unit;
  logic [CNT_W-1:0] dec_cost;
  logic [CNT_W-1:0] cnt;
  logic             accept, take;
  xop_e             op_q;

  assign accept = issue && !busy;
  assign take   = accept && special;

  spx_decode #(.WORD_W(WORD_W)) u_dec (
    .word(instr), .special(special), .op(dec_op), .unit(dec_unit), .cost(dec_cost)
  );

  spx_timer u_tmr (
    .clk(clk), .rst(rst), .start(take), .load(dec_cost - CNT_W'(1)),
    .hold((op_q == OP_HWINT) && dev_stall), .cnt(cnt), .busy(busy)
  );

  spx_stack #(.DATA_W(DATA_W)) u_stk (
    .clk(clk), .rst(rst), .call_start(take && dec_op == OP_CALL),
    .call_act(op_q == OP_CALL), .cnt(cnt), .ret_pc(ret_pc), .sp_in(sp_in),
    .target(opnd_val), .push_req(push_req), .push_addr(push_addr),
    .push_data(push_data), .pc_load(pc_load), .pc_target(pc_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_NONE;
      illegal  <= 1'b0;
      int_go   <= 1'b0;
      dev_go   <= 1'b0;
      arg_val  <= '0;
      arg_addr <= '0;
    end else begin
      illegal <= take && (dec_op == OP_BAD);
      int_go  <= take && (dec_unit == U_INT);
      dev_go  <= take && (dec_unit == U_DEV);
      if (accept)
        op_q <= special ? dec_op : OP_NONE;
      if (take && dec_unit != U_CORE) begin
        arg_val  <= opnd_val;
        arg_addr <= opnd_addr;
      end
    end
  end

  assign op_code = op_q;
endmodule

// File: rtl/spx_sequencer_chk.sv
module spx_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [3:0] op_code,
  input logic       illegal,
  input logic       int_go,
  input logic       dev_go,
  input logic       push_req,
  input logic       pc_load,
  input logic       dev_stall
);
  p_op_held_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(op_code));
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({int_go, dev_go, illegal, push_req}));
  p_push_then_load_r6: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> $past(push_req));
  p_load_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> busy);
  p_push_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
    push_req |-> busy);
  p_bad_is_single_r7: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !busy);
  p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && op_code == 4'd9 && dev_stall) |=> busy);
endmodule

bind spx_sequencer spx_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .op_code(op_code), .illegal(illegal),
  .int_go(int_go), .dev_go(dev_go), .push_req(push_req), .pc_load(pc_load),
  .dev_stall(dev_stall)
);

// File: tb/spx_sequencer_test.sv
module spx_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [15:0] instr = '0, opnd_val = '0, opnd_addr = '0, ret_pc = '0, sp_in = '0;
  logic        dev_stall = 1'b0;
  logic        busy, illegal, int_go, dev_go, push_req, pc_load;
  logic [3:0]  op_code;
  logic [15:0] arg_val, arg_addr, push_addr, push_data, pc_target;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spx_sequencer uut (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr), .opnd_val(opnd_val),
    .opnd_addr(opnd_addr), .ret_pc(ret_pc), .sp_in(sp_in), .dev_stall(dev_stall),
    .busy(busy), .op_code(op_code), .illegal(illegal), .int_go(int_go),
    .dev_go(dev_go), .arg_val(arg_val), .arg_addr(arg_addr), .push_req(push_req),
    .push_addr(push_addr), .push_data(push_data), .pc_load(pc_load),
    .pc_target(pc_target)
  );

  // behavioural reference
  int          m_rem = 0, m_op = 0;
  bit          m_push, m_pcl, m_ill, m_ig, m_dg;
  logic [15:0] m_pa = 0, m_pd = 0, m_pt = 0, m_av = 0, m_aa = 0;

  task automatic lookup(input int sel, output int op, output int cost, output int kind);
    kind = 0;
    case (sel)
      1:  begin op = 1; cost = 3; end
      8:  begin op = 2; cost = 4; kind = 1; end
      9:  begin op = 3; cost = 1; kind = 1; end
      10: begin op = 4; cost = 1; kind = 1; end
      11: begin op = 5; cost = 3; kind = 1; end
      12: begin op = 6; cost = 2; kind = 1; end
      16: begin op = 7; cost = 2; kind = 2; end
      17: begin op = 8; cost = 4; kind = 2; end
      18: begin op = 9; cost = 4; kind = 2; end
      default: begin op = 10; cost = 1; end
    endcase
  endtask

  always @(posedge clk) begin
    int op, cost, kind;
    m_push = 0; m_pcl = 0; m_ill = 0; m_ig = 0; m_dg = 0;
    if (rst) begin
      m_rem = 0; m_op = 0; m_pa = 0; m_pd = 0; m_pt = 0; m_av = 0; m_aa = 0;
    end else if (m_rem > 0) begin
      if (m_op == 1 && m_rem == 2) m_pcl = 1;
      if (!(m_rem == 1 && m_op == 9 && dev_stall)) m_rem = m_rem - 1;
    end else if (issue) begin
      if (instr[4:0] != 5'd0) m_op = 0;
      else begin
        lookup(int'(instr[9:5]), op, cost, kind);
        m_op = op; m_rem = cost - 1;
        if (op == 1) begin
          m_push = 1; m_pa = sp_in - 16'd1; m_pd = ret_pc; m_pt = opnd_val;
        end
        if (op == 10) m_ill = 1;
        if (kind == 1) m_ig = 1;
        if (kind == 2) m_dg = 1;
        if (kind != 0) begin m_av = opnd_val; m_aa = opnd_addr; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk("R3 busy", 32'(busy), 32'(m_rem > 0));
      chk("R2 op_code", 32'(op_code), 32'(m_op));
      chk("R7 illegal", 32'(illegal), 32'(m_ill));
      chk("R8 int_go/dev_go", {30'd0, int_go, dev_go}, {30'd0, m_ig, m_dg});
      chk("R8 arg", {arg_val, arg_addr}, {m_av, m_aa});
      chk("R5 push", {15'd0, push_req, push_addr}, {15'd0, m_push, m_pa});
      chk("R5 push_data", 32'(push_data), 32'(m_pd));
      chk("R6 pc", {15'd0, pc_load, pc_target}, {15'd0, m_pcl, m_pt});
    end
  end

  task automatic send(input logic [4:0] sel, input logic [5:0] a, input logic [15:0] v);
    @(negedge clk);
    issue = 1'b1; instr = {a, sel, 5'd0};
    opnd_val = v; opnd_addr = ~v; ret_pc = v + 16'h0101; sp_in = v ^ 16'h8000;
    @(negedge clk);
    issue = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    int pushes;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset", {busy, op_code, illegal, int_go, dev_go, push_req, pc_load},
        9'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after reset", {16'd0, push_addr | pc_target | arg_val | arg_addr}, 32'd0);

    // R2 R3 R7 R8: sweep every selector
    for (int s = 0; s < 32; s++)
      send(5'(s), 6'(s ^ 21), 16'h1000 + 16'(s * 977));

    // R1: basic word after a dispatched op
    send(5'h08, 6'h3, 16'hBEEF);
    @(negedge clk);
    issue = 1'b1; instr = 16'h0421;
    @(negedge clk);
    issue = 1'b0;
    chk("R1 basic word op", 32'(op_code), 32'd0);
    chk("R1 basic word idle", {busy, int_go, dev_go, illegal, push_req}, 5'd0);

    // R4: issue held high across calls
    @(negedge clk);
    pushes = 0;
    issue = 1'b1; instr = {6'h1F, 5'h01, 5'd0}; opnd_val = 16'h4321; sp_in = 16'h0000;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (push_req) pushes++;
    end
    issue = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (push_req) pushes++;
    end
    chk("R4 calls accepted", 32'(pushes), 32'd4);
    chk("R5 wrap push_addr", 32'(push_addr), 32'hFFFF);

    // R9: stalled device interrupt
    @(negedge clk);
    dev_stall = 1'b1;
    issue = 1'b1; instr = {6'h2, 5'h12, 5'd0};
    @(negedge clk);
    issue = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 stalled busy", 32'(busy), 32'd1);
    dev_stall = 1'b0;
    @(negedge clk);
    chk("R9 released", 32'(busy), 32'd0);

    // R3 R5 R6: back-to-back mix
    send(5'h01, 6'h0, 16'h7777);
    send(5'h11, 6'h1, 16'h2222);
    send(5'h0b, 6'h2, 16'h3333);
    send(5'h00, 6'h3, 16'h4444);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5 * 20000);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule